// File: doc/BRIEF.md
# Load-Use and Branch Stall Cycle Accounting Unit

This block keeps cycle statistics for an in-order core that retires either one instruction or a pair of instructions issued together. For every retiring instruction the core presents one event: a base cycle count, up to `NUM_SRC` source register numbers with a used bit each, an optional loaded destination register, a branch marker with its outcome, and two markers that say whether this instruction opens and/or closes its issue set. A single-issue instruction raises both markers in the same event.

The unit remembers which registers the previous instruction loaded. Every used source that falls in that set costs two load-stall cycles, and a taken branch costs two branch-stall cycles. The stall values build up over the whole issue set. Each instruction's total is its base plus the set's stalls so far. A pair is charged only the larger of its members' totals in the cycle counter. The load-stall and branch-stall counters, and the taken and untaken branch counts, are kept as free-standing statistics that update on every instruction.

All five counters are outputs, registered, and stop at their maximum by default. The hardware does not stall the pipeline, does not decode, and does not hold any timing tables.

Top module: `stall_acct`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets all five counters to 0 and empties the active and pending loaded-register sets, so that a source used right after reset adds no stall.
- R2: Each source slot with its used bit at 1 whose register number is in the active loaded-register set adds 2 to the set's load-stall value. A slot with its used bit at 0 never adds a stall, whatever its register number.
- R3: A load (`in_ld_vld`=1) puts bit `in_ld_reg` into the pending set. At the end of every instruction the pending set becomes the active set. A load is therefore seen by the next instruction, and a register loaded two single-issue instructions back no longer stalls.
- R4: A branch with `in_br_taken`=1 adds 2 to the set's branch-stall value and 1 to `cnt_taken`. A branch with `in_br_taken`=0 adds no stall and 1 to `cnt_untaken`. A non-branch leaves both branch counts unchanged.
- R5: An instruction with `in_first`=1 starts from zero set load-stall, zero set branch-stall, an empty pending set and a zero running maximum. Without `in_first` these carry over from the previous instruction.
- R6: An instruction's total is base + set load-stall + set branch-stall. An instruction with `in_last`=0 stores its total as the running maximum. An instruction with `in_last`=1 adds max(total, running maximum) to `cnt_cycles`.
- R7: On every instruction, `cnt_ld_stall` and `cnt_br_stall` add the set's current load-stall and branch-stall values. Stalls of the first member of a pair are therefore counted again by the second member.
- R8: With `SATURATE`=1 each counter holds at its all-ones value instead of wrapping.
- R9: While `in_valid` is 0 no counter and no loaded-register set changes. Counters update at the clock edge where `in_valid` is 1 and are visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One instruction retires this cycle |
| in_base | input | CYC_W | Base cycle count of the instruction |
| in_src_reg | input | NUM_SRC*REG_W | Source register numbers, slot 0 in the low bits |
| in_src_vld | input | NUM_SRC | Used bit per source slot |
| in_ld_vld | input | 1 | Instruction loads a register |
| in_ld_reg | input | REG_W | Loaded destination register |
| in_br | input | 1 | Instruction is a branch |
| in_br_taken | input | 1 | Branch outcome, 1 = taken |
| in_first | input | 1 | Opens an issue set |
| in_last | input | 1 | Closes an issue set |
| cnt_cycles | output | CNT_W | Accumulated charged cycles |
| cnt_ld_stall | output | CNT_W | Accumulated load-stall cycles |
| cnt_br_stall | output | CNT_W | Accumulated branch-stall cycles |
| cnt_taken | output | CNT_W | Taken branch count |
| cnt_untaken | output | CNT_W | Untaken branch count |

## Verification
The bench builds the unit with 16 registers (`REG_W`=4), two source slots, 8-bit base counts and `CNT_W`=10. With 10-bit counters, saturation at 1023 is reached after a handful of instructions with base 255, which a 32-bit counter would never reach in a short run. Random issue draws source registers from a small range, so load-use hits, hits inside a pair and stalls carried over from a pair's first member all happen often. Directed sequences pin the exact values for unused operands, expiry of the loaded set and pair maximum charging.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;
   // number of counters exposed by the unit and their slot order
   localparam int NUM_CNT  = 5;
   localparam int SLOT_CYC = 0;
   localparam int SLOT_LDS = 1;
   localparam int SLOT_BRS = 2;
   localparam int SLOT_TKN = 3;
   localparam int SLOT_UTK = 4;
   // stall cost per event
   localparam int STALL_COST = 2;
endpackage

// File: rtl/sacct_counter.sv
module sacct_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] inc,
   output logic [W-1:0] q
);
   logic [W:0] sum;
   assign sum = {1'b0, q} + {1'b0, inc};

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (en)  q <= sum[W] ? {W{1'b1}} : sum[W-1:0];
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (en)  q <= sum[W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/sacct_hazard.sv
module sacct_hazard #(
   parameter int REG_W   = 4,
   parameter int NUM_SRC = 2,
   localparam int NREGS  = 1 << REG_W,
   localparam int HIT_W  = $clog2(NUM_SRC + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     upd,
   input  logic [NUM_SRC*REG_W-1:0] src_reg,
   input  logic [NUM_SRC-1:0]       src_vld,
   input  logic [NREGS-1:0]         nxt_mask,
   output logic [HIT_W-1:0]         hit_cnt
);
   logic [NREGS-1:0]   act_mask;
   logic [NUM_SRC-1:0] hit;

   always_ff @(posedge clk) begin
      if (rst)      act_mask <= '0;
      else if (upd) act_mask <= nxt_mask;
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = src_vld[s] & act_mask[src_reg[s*REG_W +: REG_W]];
   end

   always_comb begin
      hit_cnt = '0;
      for (int s = 0; s < NUM_SRC; s++) hit_cnt = hit_cnt + HIT_W'(hit[s]);
   end
endmodule

// File: rtl/stall_acct.sv
module stall_acct
   import stall_acct_pkg::*;
#(
   parameter int REG_W    = 4,
   parameter int NUM_SRC  = 2,
   parameter int CYC_W    = 8,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [CYC_W-1:0]         in_base,
   input  logic [NUM_SRC*REG_W-1:0] in_src_reg,
   input  logic [NUM_SRC-1:0]       in_src_vld,
   input  logic                     in_ld_vld,
   input  logic [REG_W-1:0]         in_ld_reg,
   input  logic                     in_br,
   input  logic                     in_br_taken,
   input  logic                     in_first,
   input  logic                     in_last,
   output logic [CNT_W-1:0]         cnt_cycles,
   output logic [CNT_W-1:0]         cnt_ld_stall,
   output logic [CNT_W-1:0]         cnt_br_stall,
   output logic [CNT_W-1:0]         cnt_taken,
   output logic [CNT_W-1:0]         cnt_untaken
);
   localparam int NREGS = 1 << REG_W;
   localparam int HIT_W = $clog2(NUM_SRC + 1);
   localparam int WW    = CNT_W + 2;

   generate
      if (REG_W < 1 || REG_W > 8)        begin : g_bad_reg  $error("REG_W out of range");  end
      if (NUM_SRC < 1 || NUM_SRC > 4)    begin : g_bad_src  $error("NUM_SRC out of range"); end
      if (CYC_W < 1 || CYC_W > CNT_W)    begin : g_bad_cyc  $error("CYC_W must fit CNT_W"); end
      if (CNT_W < 4)                     begin : g_bad_cnt  $error("CNT_W too small");      end
   endgenerate

   function automatic logic [CNT_W-1:0] clamp(input logic [WW-1:0] v);
      if (SATURATE && (v[WW-1:CNT_W] != '0)) return {CNT_W{1'b1}};
      return v[CNT_W-1:0];
   endfunction

   // per-set running state
   logic [CNT_W-1:0] ld_q, br_q, max_q;
   logic [NREGS-1:0] pend_q;

   logic [CNT_W-1:0] ld_base, br_base, max_base, ld_nxt, br_nxt, tot, charge;
   logic [NREGS-1:0] pend_nxt;
   logic [HIT_W-1:0] hit_cnt;
   logic             br_tk, br_ut;

   sacct_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_haz (
      .clk      (clk),
      .rst      (rst),
      .upd      (in_valid),
      .src_reg  (in_src_reg),
      .src_vld  (in_src_vld),
      .nxt_mask (pend_nxt),
      .hit_cnt  (hit_cnt)
   );

   assign br_tk = in_br &  in_br_taken;
   assign br_ut = in_br & ~in_br_taken;

   always_comb begin
      ld_base  = in_first ? '0 : ld_q;
      br_base  = in_first ? '0 : br_q;
      max_base = in_first ? '0 : max_q;
      pend_nxt = in_first ? '0 : pend_q;
      if (in_ld_vld) pend_nxt[in_ld_reg] = 1'b1;
      ld_nxt = clamp(WW'(ld_base) + WW'(hit_cnt) * WW'(STALL_COST));
      br_nxt = clamp(WW'(br_base) + (br_tk ? WW'(STALL_COST) : '0));
      tot    = clamp(WW'(in_base) + WW'(ld_nxt) + WW'(br_nxt));
      charge = (tot > max_base) ? tot : max_base;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ld_q   <= '0;
         br_q   <= '0;
         max_q  <= '0;
         pend_q <= '0;
      end else if (in_valid) begin
         ld_q   <= ld_nxt;
         br_q   <= br_nxt;
         pend_q <= pend_nxt;
         if (!in_last) max_q <= tot;
      end
   end

   // statistics counters
   logic [CNT_W-1:0] inc [NUM_CNT];
   logic [CNT_W-1:0] cnt [NUM_CNT];

   always_comb begin
      inc[SLOT_CYC] = in_last ? charge : '0;
      inc[SLOT_LDS] = ld_nxt;
      inc[SLOT_BRS] = br_nxt;
      inc[SLOT_TKN] = CNT_W'(br_tk);
      inc[SLOT_UTK] = CNT_W'(br_ut);
   end

   for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      sacct_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
         .clk (clk),
         .rst (rst),
         .en  (in_valid),
         .inc (inc[c]),
         .q   (cnt[c])
      );
   end

   assign cnt_cycles   = cnt[SLOT_CYC];
   assign cnt_ld_stall = cnt[SLOT_LDS];
   assign cnt_br_stall = cnt[SLOT_BRS];
   assign cnt_taken    = cnt[SLOT_TKN];
   assign cnt_untaken  = cnt[SLOT_UTK];
endmodule

// File: rtl/sacct_chk.sv
module sacct_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_br,
   input logic             in_br_taken,
   input logic [CNT_W-1:0] cnt_cycles,
   input logic [CNT_W-1:0] cnt_ld_stall,
   input logic [CNT_W-1:0] cnt_br_stall,
   input logic [CNT_W-1:0] cnt_taken,
   input logic [CNT_W-1:0] cnt_untaken
);
   logic armed;
   always_ff @(posedge clk) armed <= ~rst;

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !in_valid |=> ($stable(cnt_cycles) && $stable(cnt_ld_stall) && $stable(cnt_br_stall)
                     && $stable(cnt_taken) && $stable(cnt_untaken)));

   // R4
   taken_inc_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      (in_valid && in_br && in_br_taken && cnt_taken != {CNT_W{1'b1}})
      |=> cnt_taken == $past(cnt_taken) + 1'b1);

   // R4
   untaken_inc_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      (in_valid && in_br && !in_br_taken && cnt_untaken != {CNT_W{1'b1}})
      |=> cnt_untaken == $past(cnt_untaken) + 1'b1);

   // R8
   no_wrap_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      1'b1 |=> (cnt_cycles >= $past(cnt_cycles)) && (cnt_ld_stall >= $past(cnt_ld_stall))
               && (cnt_br_stall >= $past(cnt_br_stall)));

   // R2
   ld_even_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      (cnt_ld_stall[0] == 1'b0) || (cnt_ld_stall == {CNT_W{1'b1}}));

   // R4
   br_even_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      (cnt_br_stall[0] == 1'b0) || (cnt_br_stall == {CNT_W{1'b1}}));
endmodule

bind stall_acct sacct_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .in_valid     (in_valid),
   .in_br        (in_br),
   .in_br_taken  (in_br_taken),
   .cnt_cycles   (cnt_cycles),
   .cnt_ld_stall (cnt_ld_stall),
   .cnt_br_stall (cnt_br_stall),
   .cnt_taken    (cnt_taken),
   .cnt_untaken  (cnt_untaken)
);

// File: tb/stall_acct_tb.sv
module stall_acct_tb;
   localparam int REG_W = 4, NUM_SRC = 2, CYC_W = 8, CNT_W = 10;
   localparam int CMAX = (1 << CNT_W) - 1;

   logic clk = 0, rst = 1;
   logic in_valid = 0, in_ld_vld = 0, in_br = 0, in_br_taken = 0, in_first = 0, in_last = 0;
   logic [CYC_W-1:0] in_base = '0;
   logic [NUM_SRC*REG_W-1:0] in_src_reg = '0;
   logic [NUM_SRC-1:0] in_src_vld = '0;
   logic [REG_W-1:0] in_ld_reg = '0;
   logic [CNT_W-1:0] cnt_cycles, cnt_ld_stall, cnt_br_stall, cnt_taken, cnt_untaken;

   always #5 clk = ~clk;

   stall_acct #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .CYC_W(CYC_W), .CNT_W(CNT_W), .SATURATE(1'b1)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_base(in_base), .in_src_reg(in_src_reg),
      .in_src_vld(in_src_vld), .in_ld_vld(in_ld_vld), .in_ld_reg(in_ld_reg), .in_br(in_br),
      .in_br_taken(in_br_taken), .in_first(in_first), .in_last(in_last),
      .cnt_cycles(cnt_cycles), .cnt_ld_stall(cnt_ld_stall), .cnt_br_stall(cnt_br_stall),
      .cnt_taken(cnt_taken), .cnt_untaken(cnt_untaken));

   int total = 0, bad = 0;
   // reference model state
   int m_ld, m_br, m_max, m_cyc, m_lds, m_brs, m_tk, m_ut;
   logic [15:0] m_pend, m_act;

   function automatic int sat(input int a, input int b);
      return (a + b > CMAX) ? CMAX : a + b;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(req, "cycles",   int'(cnt_cycles),   m_cyc);
      check(req, "ld_stall", int'(cnt_ld_stall), m_lds);
      check(req, "br_stall", int'(cnt_br_stall), m_brs);
      check(req, "taken",    int'(cnt_taken),    m_tk);
      check(req, "untaken",  int'(cnt_untaken),  m_ut);
   endtask

   task automatic model_reset();
      m_ld = 0; m_br = 0; m_max = 0; m_cyc = 0; m_lds = 0; m_brs = 0; m_tk = 0; m_ut = 0;
      m_pend = '0; m_act = '0;
   endtask

   task automatic do_reset();
      rst = 1; in_valid = 0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); rst = 0;
      model_reset();
   endtask

   // issue one instruction; called at a negedge, returns at the following negedge
   task automatic issue(input int base, input int s0, input bit v0, input int s1, input bit v1,
                        input bit ld, input int ldr, input bit br, input bit tk,
                        input bit first, input bit last, input string req);
      int hits, ldv, brv, mx, tot;
      logic [15:0] pend;
      in_valid = 1; in_base = CYC_W'(base);
      in_src_reg = {REG_W'(s1), REG_W'(s0)}; in_src_vld = {v1, v0};
      in_ld_vld = ld; in_ld_reg = REG_W'(ldr); in_br = br; in_br_taken = tk;
      in_first = first; in_last = last;
      @(posedge clk);
      hits = 0;
      if (v0 && m_act[s0]) hits++;
      if (v1 && m_act[s1]) hits++;
      ldv  = first ? 0 : m_ld;
      brv  = first ? 0 : m_br;
      mx   = first ? 0 : m_max;
      pend = first ? 16'h0 : m_pend;
      if (ld) pend[ldr] = 1'b1;
      ldv = sat(ldv, 2 * hits);
      if (br && tk) brv = sat(brv, 2);
      tot = sat(sat(base, ldv), brv);
      if (last) m_cyc = sat(m_cyc, (tot > mx) ? tot : mx);
      else m_max = tot;
      m_lds = sat(m_lds, ldv);
      m_brs = sat(m_brs, brv);
      if (br && tk) m_tk = sat(m_tk, 1);
      if (br && !tk) m_ut = sat(m_ut, 1);
      m_ld = ldv; m_br = brv; m_pend = pend; m_act = pend;
      @(negedge clk);
      in_valid = 0;
      check_all(req);
   endtask

   task automatic single(input int base, input int s0, input bit v0, input bit ld, input int ldr,
                         input bit br, input bit tk, input string req);
      issue(base, s0, v0, 0, 1'b0, ld, ldr, br, tk, 1'b1, 1'b1, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int seed;
      seed = 7;
      void'($urandom(seed));
      model_reset();
      do_reset();
      check_all("R1");

      // R3: load r3, then use r3 -> hit
      single(1, 0, 1'b0, 1'b1, 3, 1'b0, 1'b0, "R3");
      single(1, 3, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R2");
      check("R2", "ld_stall literal", int'(cnt_ld_stall), 2);
      // R3: two instructions back -> no stall
      single(1, 3, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R3");
      check("R3", "ld_stall literal", int'(cnt_ld_stall), 2);
      // R2: unused operand naming a loaded register
      single(1, 0, 1'b0, 1'b1, 5, 1'b0, 1'b0, "R2");
      issue(1, 5, 1'b0, 5, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
      check("R2", "unused operand ld_stall", int'(cnt_ld_stall), 2);
      check("R2", "cycles literal", int'(cnt_cycles), 7);
      // R4
      single(1, 0, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R4");
      check("R4", "taken br_stall literal", int'(cnt_br_stall), 2);
      single(1, 0, 1'b0, 1'b0, 0, 1'b1, 1'b0, "R4");
      check("R4", "untaken literal", int'(cnt_untaken), 1);
      check("R4", "cycles literal", int'(cnt_cycles), 11);
      // R6: pair, load in first member used by second
      issue(2, 0, 1'b0, 0, 1'b0, 1'b1, 7, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
      check("R6", "no charge before last", int'(cnt_cycles), 11);
      issue(1, 7, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
      check("R6", "pair charged max", int'(cnt_cycles), 14);
      // R6: larger first member
      issue(5, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
      issue(1, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
      check("R6", "first member larger", int'(cnt_cycles), 19);
      // R7 / R5: branch stall carried into second member and counted twice
      issue(1, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
      issue(1, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
      check("R7", "br_stall double counted", int'(cnt_br_stall), 6);
      check("R5", "carried stall in total", int'(cnt_cycles), 22);
      single(1, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R5");
      check("R5", "first clears set stalls", int'(cnt_cycles), 23);
      check("R5", "br_stall unchanged", int'(cnt_br_stall), 6);

      // R9: idle cycles with busy inputs
      in_valid = 0; in_base = 8'hff; in_br = 1; in_br_taken = 1; in_first = 1; in_last = 1;
      in_src_vld = '1;
      repeat (3) @(negedge clk);
      check_all("R9");

      // R1: reset after activity, then use of a loaded register adds nothing
      single(1, 0, 1'b0, 1'b1, 9, 1'b0, 1'b0, "R1");
      do_reset();
      check_all("R1");
      single(1, 9, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R1");
      check("R1", "mask cleared", int'(cnt_ld_stall), 0);

      // random mix of singles and pairs
      for (int i = 0; i < 300; i++) begin
         bit pair;
         pair = ($urandom % 3) == 0;
         for (int k = 0; k < (pair ? 2 : 1); k++) begin
            issue(int'($urandom % 4), int'($urandom % 4), 1'($urandom), int'($urandom % 4), 1'($urandom),
                  1'($urandom), int'($urandom % 4), 1'(($urandom % 3) == 0), 1'($urandom),
                  pair ? (k == 0) : 1'b1, pair ? (k == 1) : 1'b1, "R6");
            if (($urandom % 5) == 0) begin
               @(negedge clk);
               check_all("R9");
            end
         end
      end

      // R8: saturation
      do_reset();
      for (int i = 0; i < 6; i++) single(255, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R8");
      check("R8", "cycles saturated", int'(cnt_cycles), CMAX);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule